// File: doc/BRIEF.md
# Serial Control Port Slave with Register Bus

This block lets an external host reach an on-chip byte-wide register or memory space over four wires: an active-low frame latch, a serial clock, a serial data input and a serial data output with its own enable. The enable lets a pad drive the output or leave it at high impedance, so several slaves can share one readback wire. The block starts out inactive. It only serves frames after the host has pulled the latch line low three times.

Each frame starts with a header byte. Its upper seven bits are a chip address, which must equal the value chosen by one select pin. Its lowest bit picks read or write. Two location bytes follow, high byte first. Data bytes then run until the latch line rises. Each data byte goes to the next location up, so one frame can move a burst of any length. On the storage side the block issues one-cycle write and read strobes with an address and write data on a plain synchronous bus. Read data must be valid in the same cycle as the read strobe.

All four serial wires are sampled in the system clock domain through two-stage synchronizers followed by edge detection. The system clock must therefore run at least four times the serial clock rate.

States of the controller:
- `ST_UNARMED`: the state after reset. It moves to `ST_IDLE` once the arming counter has seen three latch pulses.
- `ST_IDLE`: waits between frames. It moves to `ST_HEADER` when the latch line falls.
- `ST_HEADER`: takes in the header byte and the location bytes. It moves to `ST_SKIP` when the chip address does not match. After the last location byte it moves to `ST_READ` or `ST_WRITE`.
- `ST_WRITE`, `ST_READ` and `ST_SKIP`: data phases. Each returns to `ST_IDLE` when the latch line rises.
- A latch rise in `ST_HEADER` also returns to `ST_IDLE`.

Top module: `spi_regport`

## Requirements
- R1: After reset the port is unarmed. While unarmed, frames cause no strobes and `sdo_oe` stays 0. The rising end of the third low pulse on `lat_n` arms the port, and the port stays armed until reset. A full frame sent while unarmed counts as one of those pulses.
- R2: Bits 7:1 of header byte 0 are compared with {6'b000000, `chip_sel`}. On a mismatch the rest of the frame causes no strobes, and `sdo_oe` stays 0 until the next frame.
- R3: Bit 0 of header byte 0 selects the frame type: 1 for read, 0 for write.
- R4: `sdi` is sampled on rising edges of `sck`, most significant bit first. Bytes 1 and 2 form the 16-bit location, high byte first.
- R5: In a write frame, each completed data byte gives exactly one `reg_we` pulse. The pulse carries `reg_addr` = start location + byte index (modulo 2^16) and `reg_wdata` = that byte.
- R6: In a read frame, one `reg_re` pulse is issued when byte 2 completes, with `reg_addr` = start location. Another is issued after each completed data byte, at the next location up. `reg_rdata` is taken in the cycle of the pulse.
- R7: `sdo` changes only after falling edges of `sck`. The first falling edge after byte 2 presents bit 7 of the first read byte, and each later falling edge presents the next bit, MSB first.
- R8: `sdo_oe` is 1 only in a matched read frame, from the end of byte 2 until the latch line rises. It is 0 one cycle after the synchronized latch rise. Whenever `sdo_oe` is 0, `sdo` is 0.
- R9: A fall of the latch line clears all shift state. A frame that ends partway through a byte writes nothing for that partial byte. A frame cut short inside the header leaves the next frame unaffected.
- R10: `reg_we` and `reg_re` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 1 | Selects the chip address this port answers to |
| lat_n | input | 1 | Frame latch; low during a frame |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial readback data |
| sdo_oe | output | 1 | Drive enable for the readback pad |
| reg_addr | output | 16 | Register bus location |
| reg_wdata | output | 8 | Register bus write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle of `reg_re` |

## Verification
The bound checker watches several rules on every cycle:
- no strobe and no output drive while the port is unarmed;
- no overlapping or back-to-back strobes;
- a location one higher after every write;
- a quiet output whenever the enable is low;
- the enable dropping right after the synchronized latch rise.

Only the bench's frames can show the rest:
- the exact arming count;
- chip address matching for both select values;
- the MSB-first order of header and data;
- the bit-by-bit readback on falling edges;
- the location carry across a byte boundary;
- dropping a partial byte.

Both directed frames and seeded random bursts are used for these.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    // Controller states of the serial port
    typedef enum logic [2:0] {
        ST_UNARMED,
        ST_IDLE,
        ST_HEADER,
        ST_WRITE,
        ST_READ,
        ST_SKIP
    } port_state_e;

endpackage

// File: rtl/spi_sync_bit.sv
// Multi-stage synchronizer for one asynchronous input.
module spi_sync_bit #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_mode_arm.sv
// Counts completed low pulses on the latch line until the port is armed.
module spi_mode_arm #(
    parameter int PULSES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_end,
    output logic armed
);
    localparam int CW = $clog2(PULSES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (pulse_end && (cnt != CW'(PULSES))) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign armed = (cnt == CW'(PULSES));
endmodule

// File: rtl/spi_rx_shift.sv
// Serial-in shift register with bit counter; reports each completed word.
module spi_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         stb,
    input  logic         din,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (clr) begin
            sh  <= '0;
            cnt <= '0;
        end else if (stb) begin
            sh  <= {sh[W-2:0], din};
            cnt <= (cnt == CW'(W - 1)) ? '0 : cnt + 1'b1;
        end
    end

    assign done = stb && !clr && (cnt == CW'(W - 1));
    assign word = {sh[W-2:0], din};
endmodule

// File: rtl/spi_tx_shift.sv
// Readback shifter: holds the prefetched word and presents one bit per
// falling serial clock edge, most significant bit first.
module spi_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         cap,
    input  logic [W-1:0] cap_data,
    input  logic         shift,
    output logic         sdo
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  pend;
    logic [W-1:0]  sh;
    logic [CW-1:0] cnt;
    logic          sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= '0;
            sh    <= '0;
            cnt   <= '0;
            sdo_q <= 1'b0;
        end else if (clr) begin
            pend  <= '0;
            sh    <= '0;
            cnt   <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (cap) begin
                pend <= cap_data;
            end
            if (shift) begin
                if (cnt == '0) begin
                    sdo_q <= pend[W-1];
                    sh    <= {pend[W-2:0], 1'b0};
                end else begin
                    sdo_q <= sh[W-1];
                    sh    <= {sh[W-2:0], 1'b0};
                end
                cnt <= (cnt == CW'(W - 1)) ? '0 : cnt + 1'b1;
            end
        end
    end

    assign sdo = sdo_q;
endmodule

// File: rtl/spi_regport.sv
// Serial control port slave giving a host byte access to a register space.
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LOC_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ARM_PULSES  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel,
    input  logic              lat_n,
    input  logic              sck,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [LOC_W-1:0]  reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int CHIP_W    = DATA_W - 1;
    localparam int LOC_BYTES = LOC_W / DATA_W;
    localparam int IDX_W     = $clog2(LOC_BYTES + 1);
    localparam int N_SYNC    = 3;
    localparam logic [N_SYNC-1:0] SYNC_RST = 3'b001;  // latch idles high

    // ---------------- input synchronization ----------------
    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] sync_q;

    assign raw_in = {sdi, sck, lat_n};

    for (genvar gi = 0; gi < N_SYNC; gi++) begin : g_sync
        spi_sync_bit #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (SYNC_RST[gi])
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_in[gi]),
            .q     (sync_q[gi])
        );
    end

    logic lat_lvl, sck_lvl, sdi_lvl;
    logic lat_prev, sck_prev;
    logic lat_fall, lat_rise, sck_rise, sck_fall;

    assign lat_lvl = sync_q[0];
    assign sck_lvl = sync_q[1];
    assign sdi_lvl = sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_prev <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            lat_prev <= lat_lvl;
            sck_prev <= sck_lvl;
        end
    end

    assign lat_fall = !lat_lvl && lat_prev;
    assign lat_rise = lat_lvl && !lat_prev;
    assign sck_rise = sck_lvl && !sck_prev;
    assign sck_fall = !sck_lvl && sck_prev;

    // ---------------- arming ----------------
    logic armed;

    spi_mode_arm #(
        .PULSES (ARM_PULSES)
    ) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_end (lat_rise),
        .armed     (armed)
    );

    // ---------------- byte reception ----------------
    logic              byte_done;
    logic [DATA_W-1:0] byte_val;

    spi_rx_shift #(
        .W (DATA_W)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (lat_fall),
        .stb   (sck_rise),
        .din   (sdi_lvl),
        .done  (byte_done),
        .word  (byte_val)
    );

    // ---------------- controller ----------------
    port_state_e state, state_nx;
    logic [IDX_W-1:0] hdr_idx;
    logic             rw_q;
    logic [LOC_W-1:0] loc;
    logic             chip_ok;

    assign chip_ok = (byte_val[DATA_W-1:1] == CHIP_W'(chip_sel));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_UNARMED: if (armed) state_nx = ST_IDLE;
            ST_IDLE:    if (lat_fall) state_nx = ST_HEADER;
            ST_HEADER: begin
                if (lat_rise) begin
                    state_nx = ST_IDLE;
                end else if (byte_done) begin
                    if (hdr_idx == '0) begin
                        if (!chip_ok) state_nx = ST_SKIP;
                    end else if (hdr_idx == IDX_W'(LOC_BYTES)) begin
                        state_nx = rw_q ? ST_READ : ST_WRITE;
                    end
                end
            end
            ST_WRITE, ST_READ, ST_SKIP: if (lat_rise) state_nx = ST_IDLE;
            default:    state_nx = ST_UNARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_UNARMED;
        end else begin
            state <= state_nx;
        end
    end

    // Datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_idx   <= '0;
            rw_q      <= 1'b0;
            loc       <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            reg_re <= 1'b0;
            if (reg_we) begin
                loc <= loc + 1'b1;
            end
            if (lat_fall) begin
                hdr_idx <= '0;
            end else begin
                unique case (state)
                    ST_HEADER: begin
                        if (byte_done && !lat_rise) begin
                            hdr_idx <= hdr_idx + 1'b1;
                            if (hdr_idx == '0) begin
                                rw_q <= byte_val[0];
                            end else begin
                                loc <= {loc[LOC_W-DATA_W-1:0], byte_val};
                                if (hdr_idx == IDX_W'(LOC_BYTES) && rw_q) begin
                                    reg_re <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_WRITE: begin
                        if (byte_done && !lat_rise) begin
                            reg_wdata <= byte_val;
                            reg_we    <= 1'b1;
                        end
                    end
                    ST_READ: begin
                        if (byte_done && !lat_rise) begin
                            loc    <= loc + 1'b1;
                            reg_re <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_addr = loc;
    assign sdo_oe   = (state == ST_READ);

    // ---------------- readback ----------------
    spi_tx_shift #(
        .W (DATA_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (lat_fall || lat_rise),
        .cap      (reg_re && (state == ST_READ)),
        .cap_data (reg_rdata),
        .shift    (sck_fall && (state == ST_READ)),
        .sdo      (sdo)
    );

endmodule

// File: rtl/spi_regport_chk.sv
// Cycle-by-cycle rules of the serial port, bound to the top module.
module spi_regport_chk #(
    parameter int LOC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             armed,
    input logic             lat_lvl,
    input logic             reg_we,
    input logic             reg_re,
    input logic [LOC_W-1:0] reg_addr,
    input logic             sdo,
    input logic             sdo_oe
);
    p_unarmed_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!reg_we && !reg_re && !sdo_oe));

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    p_we_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_re_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    p_burst_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == LOC_W'($past(reg_addr) + 1'b1)));

    p_quiet_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_lvl) |=> !sdo_oe);
endmodule

bind spi_regport spi_regport_chk #(.LOC_W(LOC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .lat_lvl  (lat_lvl),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
);

// File: tb/test_spi_regport.sv
module test_spi_regport;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;   // serial half period in system clocks
    localparam int LOGN       = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_sel = 1'b0;
    logic        lat_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo, sdo_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we, reg_re;
    logic [7:0]  reg_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regport i_spi_regport (
        .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .lat_n(lat_n),
        .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    // Storage model and strobe logs
    logic [7:0]  mem [256];
    logic [15:0] we_addr [LOGN];
    logic [7:0]  we_data [LOGN];
    logic [15:0] re_addr [LOGN];
    int          we_total = 0, re_total = 0, strobe_bad = 0;
    logic        we_prev = 1'b0, re_prev = 1'b0;

    assign reg_rdata = mem[reg_addr[7:0]];

    function automatic logic [7:0] init_val(input int i);
        return 8'(i * 37 + 5);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
        end else begin
            if (reg_we) begin
                mem[reg_addr[7:0]] <= reg_wdata;
                if (we_total < LOGN) begin
                    we_addr[we_total] <= reg_addr;
                    we_data[we_total] <= reg_wdata;
                end
                we_total <= we_total + 1;
            end
            if (reg_re) begin
                if (re_total < LOGN) re_addr[re_total] <= reg_addr;
                re_total <= re_total + 1;
            end
            if ((reg_we && reg_re) || (reg_we && we_prev) || (reg_re && re_prev))
                strobe_bad <= strobe_bad + 1;
        end
        we_prev <= reg_we;
        re_prev <= reg_re;
    end

    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_loc(input logic [15:0] base, input int k);
        return 16'(base + k);
    endfunction

    // Frame driving
    logic [7:0] wbuf [8];
    logic [7:0] got  [8];
    bit         oe_all, oe_any;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, output logic s);
        sdi = b;
        wait_clk(H);
        s = sdo;
        if (sdo_oe) oe_any = 1; else oe_all = 0;
        sck = 1'b1;
        wait_clk(H);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) send_bit(b[i], r[i]);
    endtask

    task automatic run_frame(input logic [6:0] chip, input logic rw,
                             input logic [15:0] loc, input int nbytes,
                             input int extra_bits);
        logic [7:0] dummy;
        logic       sb;
        lat_n = 1'b0;
        wait_clk(H);
        send_byte({chip, rw}, dummy);
        send_byte(loc[15:8], dummy);
        send_byte(loc[7:0], dummy);
        oe_all = 1; oe_any = 0;
        for (int k = 0; k < nbytes; k++) send_byte(wbuf[k], got[k]);
        for (int j = 0; j < extra_bits; j++) send_bit(1'b1, sb);
        wait_clk(H);
        lat_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic latch_pulse();
        lat_n = 1'b0; wait_clk(4);
        lat_n = 1'b1; wait_clk(4);
    endtask

    task automatic check_write(input logic [15:0] loc, input int n, input bit ok,
                               input int w0, input string req);
        int expn = ok ? n : 0;
        chk(we_total - w0 == expn, req, we_total - w0, expn);
        for (int k = 0; k < expn; k++) begin
            chk(we_addr[w0 + k] == exp_loc(loc, k), "R5 addr", we_addr[w0 + k], exp_loc(loc, k));
            chk(we_data[w0 + k] == wbuf[k], "R5 data", we_data[w0 + k], wbuf[k]);
        end
    endtask

    task automatic check_read(input logic [15:0] loc, input int n, input bit ok,
                              input int r0, input string req);
        int expn = ok ? n + 1 : 0;
        chk(re_total - r0 == expn, req, re_total - r0, expn);
        if (ok) begin
            for (int k = 0; k < n; k++) begin
                chk(re_addr[r0 + k] == exp_loc(loc, k), "R6 addr", re_addr[r0 + k], exp_loc(loc, k));
                chk(got[k] == mem[exp_loc(loc, k)[7:0]], "R7 sdo byte", got[k], mem[exp_loc(loc, k)[7:0]]);
            end
            chk(oe_all == 1, "R8 oe during data", oe_all, 1);
        end else begin
            chk(oe_any == 0, "R2 oe on mismatch", oe_any, 0);
        end
        chk(sdo_oe == 0, "R8 oe after frame", sdo_oe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int w0, r0, n;
        logic [15:0] loc;
        logic [6:0]  chip;
        logic        rw;
        bit          match;
        void'($urandom(32'h5EED1234));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        // reset state
        chk(sdo_oe == 0, "R8 reset oe", sdo_oe, 0);
        chk(reg_we == 0 && reg_re == 0, "R10 reset strobes", {reg_we, reg_re}, 0);

        // R1: frames before arming are ignored; the frame counts as pulse one
        wbuf[0] = 8'h3C;
        w0 = we_total; r0 = re_total;
        run_frame(7'd0, 1'b0, 16'h0010, 1, 0);
        latch_pulse();
        check_write(16'h0010, 1, 0, w0, "R1 unarmed write");
        w0 = we_total;
        run_frame(7'd0, 1'b1, 16'h0010, 1, 0);   // pulse three: still ignored
        chk(we_total == w0 && re_total == r0, "R1 unarmed read", re_total - r0, 0);
        chk(oe_any == 0, "R1 unarmed oe", oe_any, 0);

        // R3 R4 R5: single write, now armed
        wbuf[0] = 8'hA5;
        w0 = we_total;
        run_frame(7'd0, 1'b0, 16'h12F0, 1, 0);
        check_write(16'h12F0, 1, 1, w0, "R5 single write");

        // R5: burst with carry into the high byte
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        w0 = we_total;
        run_frame(7'd0, 1'b0, 16'h12FE, 4, 0);
        check_write(16'h12FE, 4, 1, w0, "R5 burst carry");

        // R2: wrong chip address, write and read
        w0 = we_total; r0 = re_total;
        run_frame(7'd1, 1'b0, 16'h0020, 2, 0);
        check_write(16'h0020, 2, 0, w0, "R2 mismatch write");
        run_frame(7'd1, 1'b1, 16'h0020, 2, 0);
        check_read(16'h0020, 2, 0, r0, "R2 mismatch read");

        // R2: select pin high answers to address 1
        chip_sel = 1'b1;
        wbuf[0] = 8'h5A;
        w0 = we_total;
        run_frame(7'd1, 1'b0, 16'h0030, 1, 0);
        check_write(16'h0030, 1, 1, w0, "R2 select high");

        // R6 R7 R8: single and burst reads
        r0 = re_total;
        run_frame(7'd1, 1'b1, 16'h0040, 1, 0);
        check_read(16'h0040, 1, 1, r0, "R6 single read");
        r0 = re_total;
        run_frame(7'd1, 1'b1, 16'h00FE, 3, 0);
        check_read(16'h00FE, 3, 1, r0, "R6 burst read");

        // R9: partial trailing byte is dropped
        wbuf[0] = 8'h77;
        w0 = we_total;
        run_frame(7'd1, 1'b0, 16'h0050, 1, 5);
        check_write(16'h0050, 1, 1, w0, "R9 partial byte");

        // R9: frame cut inside the header, then a clean frame
        w0 = we_total;
        lat_n = 1'b0; wait_clk(H);
        begin
            logic [7:0] d;
            send_byte({7'd1, 1'b0}, d);
            for (int j = 0; j < 3; j++) send_bit(1'b1, d[0]);
        end
        wait_clk(H); lat_n = 1'b1; wait_clk(2 * H);
        chk(we_total == w0, "R9 header abort", we_total - w0, 0);
        wbuf[0] = 8'h99;
        run_frame(7'd1, 1'b0, 16'h0060, 1, 0);
        check_write(16'h0060, 1, 1, w0, "R9 recovery");

        // Seeded random frames
        for (int it = 0; it < 16; it++) begin
            match = ($urandom % 5) != 0;
            chip  = match ? {6'd0, chip_sel} : 7'(($urandom % 126) + 2);
            rw    = 1'($urandom);
            loc   = 16'($urandom);
            n     = ($urandom % 4) + 1;
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            w0 = we_total; r0 = re_total;
            run_frame(chip, rw, loc, n, 0);
            if (rw) check_read(loc, n, match, r0, "R6 random read");
            else    check_write(loc, n, match, w0, "R5 random write");
        end

        chk(strobe_bad == 0, "R10 strobe overlap", strobe_bad, 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule